// File: doc/BRIEF.md
# Exception Frame Sequencer

This block sits next to a small processor core and turns exception requests into supervisor-stack writes. Eleven request lines are latched as they arrive. The block sorts each one into one of three priority groups and grants the most urgent. For the granted exception it emits a stream of 16-bit stack writes. Each write first lowers a 32-bit supervisor stack pointer by 2 and then stores one word at the new address.

A frame is built from the status word, the program counter of the next instruction and the vector number, all sampled when the request is granted. The length of the frame depends on the group and on a frame-mode input. In the extended mode the frame also carries a 4-bit format code and the vector offset, so that a later return can tell how much to unstack. After the last word has been written, a one-cycle done strobe reports which source was served, its group, and the new stack pointer.

The write stream is valid/ready. A word stays offered, with its address and data unchanged, until `wr_ready` is seen high at a rising edge. Only that handshake moves the stack pointer and advances to the next word. Holding `wr_ready` low stalls the sequence for as long as it is held, and no word is lost. The request lines and the done strobe are plain control pins.

Top module: `exc_frame_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `wr_valid` and `done` stay low.
- R2: Source indices on `req` are: 0 reset, 1 bus error, 2 address error (group 0); 3 trace, 4 interrupt, 5 illegal, 6 privilege (group 1); 7 trap, 8 trap-on-overflow, 9 bounds check, 10 divide by zero (group 2). Among pending sources the lowest index is granted, so group 0 beats group 1, group 1 beats group 2, and the order inside a group is fixed.
- R3: A request seen at a rising edge while the block is idle is granted at that edge. The first write (or `done`, for reset) is presented in the cycle right after that edge.
- R4: Source 0 writes nothing. `done` follows in the cycle after the grant, with `ssp_out` equal to the sampled `ssp_in`.
- R5: With `frame_ext`=0, every other source writes 3 words. The write order is PC[15:0] at ssp-2, then PC[31:16] at ssp-4, then SR at ssp-6.
- R6: With `frame_ext`=1, a group 1 or group 2 source writes 4 words. The first word, at ssp-2, is the format word {4'b0000, 2'b00, vector, 2'b00}: format code in bits 15:12, vector times 4 in bits 11:0. It is followed by PC low, PC high and SR, which lands at ssp-8.
- R7: With `frame_ext`=1, a bus or address error writes 29 words. First come 25 zero words, starting at ssp-2. Then follow the format word with code 4'b1000, PC low, PC high, and SR at ssp-58.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last handshake. `done_src`, `done_grp` (0, 1 or 2) and `ssp_out` (the final stack pointer) are valid during it.
- R10: Requests that arrive while a frame is in progress stay pending. They are served one after another in R2 order, and each granted source is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 11 | Exception request pulses, one bit per source (R2 indices) |
| frame_ext | input | 1 | Extended frame mode, sampled at grant |
| sr_in | input | 16 | Status word, sampled at grant |
| pc_in | input | 32 | Next-instruction address, sampled at grant |
| vec_in | input | 8 | Vector number, sampled at grant |
| ssp_in | input | 32 | Supervisor stack pointer before the frame, sampled at grant |
| wr_valid | output | 1 | A stack write is offered |
| wr_ready | input | 1 | Receiver accepts the offered write |
| wr_addr | output | 32 | Byte address of the offered word |
| wr_data | output | 16 | Offered word |
| done | output | 1 | Frame finished (one-cycle pulse) |
| done_src | output | 4 | Source index served |
| done_grp | output | 2 | Group of the served source |
| ssp_out | output | 32 | Stack pointer after the frame |

## Verification
A request driven 1 ns after a rising edge is granted at the next rising edge. `wr_valid`, or `done` for reset, must be high at the falling edge of the cycle right after that grant edge. Each following word appears one cycle after each handshake, and `done` appears one cycle after the last handshake. The bench therefore drives every input 1 ns after a rising edge and samples every output at the falling edge. It counts a handshake only when `wr_valid` and `wr_ready` are both high there, and on each stalled sample it checks that the next sample holds the same address and data.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int NSRC     = 11;
  localparam int SRC_W    = 4;
  localparam int G1_FIRST = 3;
  localparam int G2_FIRST = 7;

  typedef enum logic [1:0] {GRP_0 = 2'd0, GRP_1 = 2'd1, GRP_2 = 2'd2} grp_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DONE} st_e;

  function automatic grp_e grp_of(input logic [SRC_W-1:0] s);
    if (s < SRC_W'(G1_FIRST))      return GRP_0;
    else if (s < SRC_W'(G2_FIRST)) return GRP_1;
    else                           return GRP_2;
  endfunction
endpackage

// File: rtl/exc_pending_arb.sv
module exc_pending_arb
  import exc_seq_pkg::*;
#(
  parameter int N   = NSRC,
  parameter int ID_W = SRC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            take,
  output logic            any,
  output logic [ID_W-1:0] pick_id,
  output logic [N-1:0]    pick_oh
);
  logic [N-1:0] pending_q;
  logic [N-1:0] comb;

  assign comb    = pending_q | req;
  assign any     = |comb;
  assign pick_oh = comb & (~comb + N'(1));

  always_comb begin
    pick_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (comb[i]) pick_id = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pending_q <= '0;
    else if (take) pending_q <= comb & ~pick_oh;
    else           pending_q <= comb;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
  // R2
  grant_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pick_oh == (N'(1) << pick_id)));
  // R10
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && any) |=> ((pending_q & $past(comb)) == $past(comb)));
endmodule

// File: rtl/exc_word_gen.sv
module exc_word_gen #(
  parameter int SLOT_W = 5,
  parameter int PC_W   = 32
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [15:0]       sr,
  input  logic [PC_W-1:0]   pc,
  input  logic [3:0]        fmt,
  input  logic [7:0]        vec,
  output logic [15:0]       word
);
  always_comb begin
    if (slot >= SLOT_W'(4))      word = 16'h0000;
    else if (slot == SLOT_W'(3)) word = {fmt, 2'b00, vec, 2'b00};
    else if (slot == SLOT_W'(2)) word = pc[15:0];
    else if (slot == SLOT_W'(1)) word = pc[31:16];
    else                         word = sr;
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int       ADDR_W        = 32,
  parameter int       G0_LONG_WORDS = 29,
  parameter int       SHORT_WORDS   = 3,
  parameter int       EXT_WORDS     = 4,
  parameter logic [3:0] FMT_LONG    = 4'h8,
  parameter logic [3:0] FMT_SHORT   = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic              frame_ext,
  input  logic [15:0]       sr_in,
  input  logic [31:0]       pc_in,
  input  logic [7:0]        vec_in,
  input  logic [ADDR_W-1:0] ssp_in,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              done,
  output logic [SRC_W-1:0]  done_src,
  output logic [1:0]        done_grp,
  output logic [ADDR_W-1:0] ssp_out
);
  localparam int CNT_W = $clog2(G0_LONG_WORDS + 1);

  st_e               state_q;
  logic [CNT_W-1:0]  slot_q;
  logic [ADDR_W-1:0] sp_q;
  logic [15:0]       sr_q;
  logic [31:0]       pc_q;
  logic [7:0]        vec_q;
  logic [3:0]        fmt_q;
  logic [SRC_W-1:0]  src_q;
  grp_e              grp_q;

  logic              any;
  logic [SRC_W-1:0]  pick_id;
  logic [NSRC-1:0]   pick_oh;
  logic              accept;
  grp_e              pick_grp;
  logic [CNT_W-1:0]  nwords;
  logic              hs;

  assign accept   = (state_q == ST_IDLE) && any;
  assign pick_grp = grp_of(pick_id);
  assign hs       = wr_valid && wr_ready;

  exc_pending_arb #(.N(NSRC), .ID_W(SRC_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .take    (accept),
    .any     (any),
    .pick_id (pick_id),
    .pick_oh (pick_oh)
  );

  always_comb begin
    if (pick_id == '0)        nwords = '0;
    else if (!frame_ext)      nwords = CNT_W'(SHORT_WORDS);
    else if (pick_grp == GRP_0) nwords = CNT_W'(G0_LONG_WORDS);
    else                      nwords = CNT_W'(EXT_WORDS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      sp_q    <= '0;
      sr_q    <= '0;
      pc_q    <= '0;
      vec_q   <= '0;
      fmt_q   <= '0;
      src_q   <= '0;
      grp_q   <= GRP_0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          src_q  <= pick_id;
          grp_q  <= pick_grp;
          sr_q   <= sr_in;
          pc_q   <= pc_in;
          vec_q  <= vec_in;
          sp_q   <= ssp_in;
          fmt_q  <= (pick_grp == GRP_0) ? FMT_LONG : FMT_SHORT;
          if (nwords == '0) begin
            state_q <= ST_DONE;
          end else begin
            slot_q  <= nwords - CNT_W'(1);
            state_q <= ST_SEND;
          end
        end
        ST_SEND: if (wr_ready) begin
          sp_q <= sp_q - ADDR_W'(2);
          if (slot_q == '0) state_q <= ST_DONE;
          else              slot_q  <= slot_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  exc_word_gen #(.SLOT_W(CNT_W), .PC_W(32)) u_word (
    .slot (slot_q),
    .sr   (sr_q),
    .pc   (pc_q),
    .fmt  (fmt_q),
    .vec  (vec_q),
    .word (wr_data)
  );

  assign wr_valid = (state_q == ST_SEND);
  assign wr_addr  = sp_q - ADDR_W'(2);
  assign done     = (state_q == ST_DONE);
  assign done_src = src_q;
  assign done_grp = grp_q;
  assign ssp_out  = sp_q;

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && slot_q != '0) |=> (wr_valid && wr_addr == $past(wr_addr) - ADDR_W'(2)));
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && slot_q == '0) |=> (done && !wr_valid));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  prompt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wr_valid || done));
  // R4
  reset_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_id == '0) |=> (done && !wr_valid && ssp_out == $past(ssp_in)));
endmodule

// File: tb/tb_exc_frame_seq.sv
`timescale 1ns/1ps
module tb_exc_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] req = '0;
  logic        frame_ext = 1'b0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0;
  logic [7:0]  vec_in = '0;
  logic [31:0] ssp_in = '0;
  logic        wr_valid, wr_ready, done;
  logic [31:0] wr_addr, ssp_out;
  logic [15:0] wr_data;
  logic [3:0]  done_src;
  logic [1:0]  done_grp;

  always #2.5 clk = ~clk;

  exc_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .frame_ext(frame_ext),
    .sr_in(sr_in), .pc_in(pc_in), .vec_in(vec_in), .ssp_in(ssp_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .done_src(done_src),
    .done_grp(done_grp), .ssp_out(ssp_out)
  );

  int checks = 0;
  int fails = 0;
  int exp_done = 0;
  int done_seen = 0;
  bit bp_mode = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  logic [31:0] wq_a[$];
  logic [15:0] wq_d[$];
  string       wq_t[$];
  logic [3:0]  dq_s[$];
  logic [1:0]  dq_g[$];
  logic [31:0] dq_sp[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  logic        prev_stall = 1'b0;
  logic [31:0] prev_a;
  logic [15:0] prev_d;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R8",
            "stalled word changed", {wr_addr, wr_data}, {prev_a, prev_d});
      if (wr_valid && wr_ready) begin
        if (wq_a.size() == 0) begin
          chk(1'b0, "R5", "unexpected write", wr_addr, 0);
        end else begin
          automatic logic [31:0] ea = wq_a.pop_front();
          automatic logic [15:0] ed = wq_d.pop_front();
          automatic string       et = wq_t.pop_front();
          chk(wr_addr == ea, et, "write address", wr_addr, ea);
          chk(wr_data == ed, et, "write data", wr_data, ed);
        end
      end
      if (done) begin
        done_seen++;
        if (dq_s.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", done_src, 0);
        end else begin
          automatic logic [3:0]  es = dq_s.pop_front();
          automatic logic [1:0]  eg = dq_g.pop_front();
          automatic logic [31:0] ep = dq_sp.pop_front();
          chk(done_src == es, "R9", "done source (R2 order)", done_src, es);
          chk(done_grp == eg, "R9", "done group", done_grp, eg);
          chk(ssp_out == ep, "R9", "final stack pointer", ssp_out, ep);
        end
      end
      prev_stall = wr_valid && !wr_ready;
      prev_a = wr_addr;
      prev_d = wr_data;
    end
  end

  // driver: expected frame from the requirements
  task automatic push_frame(input int src);
    automatic int grp = (src < 3) ? 0 : (src < 7) ? 1 : 2;
    automatic int n;
    automatic logic [15:0] w[29];
    automatic string tag;
    if (src == 0) begin n = 0; tag = "R4"; end
    else if (!frame_ext) begin n = 3; tag = "R5"; end
    else if (grp == 0) begin n = 29; tag = "R7"; end
    else begin n = 4; tag = "R6"; end
    for (int i = 0; i < 29; i++) w[i] = 16'h0000;
    w[0] = sr_in;
    w[1] = pc_in[31:16];
    w[2] = pc_in[15:0];
    w[3] = {(grp == 0) ? 4'h8 : 4'h0, 2'b00, vec_in, 2'b00};
    for (int i = n - 1; i >= 0; i--) begin
      wq_a.push_back(ssp_in - 32'(2 * (n - i)));
      wq_d.push_back(w[i]);
      wq_t.push_back(tag);
    end
    dq_s.push_back(4'(src));
    dq_g.push_back(2'(grp));
    dq_sp.push_back(ssp_in - 32'(2 * n));
    exp_done++;
  endtask

  task automatic pulse(input logic [10:0] m, input bit check_resp);
    @(posedge clk); #1 req = m;
    @(posedge clk); #1 req = '0;
    if (check_resp) begin
      @(negedge clk);
      chk(wr_valid || done, "R3", "no response one cycle after grant",
          {wr_valid, done}, 2'b11);
    end
  endtask

  task automatic wait_all();
    automatic int t = 0;
    while (done_seen < exp_done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    chk(done_seen == exp_done, "R9", "frames completed", done_seen, exp_done);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_seen, exp_done);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !done, "R1", "outputs during reset", {wr_valid, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_valid && !done, "R1", "idle after reset", {wr_valid, done}, 0);

    // R4: reset source
    sr_in = 16'h2700; pc_in = 32'h0000_1234; vec_in = 8'h00; ssp_in = 32'h0000_8000;
    frame_ext = 1'b1;
    push_frame(0); pulse(11'h001, 1'b1); wait_all();

    // R5: compact frame, illegal instruction
    frame_ext = 1'b0; sr_in = 16'h2014; pc_in = 32'hCAFE_0102; vec_in = 8'h04;
    ssp_in = 32'h0001_0000;
    push_frame(5); pulse(11'h020, 1'b1); wait_all();

    // R6: extended short frame, trap
    frame_ext = 1'b1; sr_in = 16'h0011; pc_in = 32'h00AB_CDEE; vec_in = 8'h21;
    ssp_in = 32'h0000_4000;
    push_frame(7); pulse(11'h080, 1'b1); wait_all();

    // R7 + R8: long frame, bus error, back-pressure
    bp_mode = 1'b1;
    sr_in = 16'hA55A; pc_in = 32'h1357_9BDF; vec_in = 8'h02; ssp_in = 32'h0000_2000;
    push_frame(1); pulse(11'h002, 1'b1); wait_all();
    bp_mode = 1'b0;

    // R5: compact frame for address error
    frame_ext = 1'b0; ssp_in = 32'h0000_3000;
    push_frame(2); pulse(11'h004, 1'b1); wait_all();

    // R2: simultaneous across groups
    frame_ext = 1'b1; ssp_in = 32'h0000_5000; vec_in = 8'h1F;
    push_frame(2); push_frame(4); push_frame(8); push_frame(10);
    pulse(11'h514, 1'b1); wait_all();

    // R2: simultaneous inside group 1
    push_frame(3); push_frame(5); push_frame(6);
    pulse(11'h068, 1'b1); wait_all();

    // R10: requests arriving while busy
    bp_mode = 1'b1; ssp_in = 32'h0000_6000;
    push_frame(1); push_frame(4); push_frame(9);
    pulse(11'h002, 1'b1);
    repeat (3) @(posedge clk);
    pulse(11'h200, 1'b0);
    repeat (2) @(posedge clk);
    pulse(11'h010, 1'b0);
    wait_all();
    bp_mode = 1'b0;

    // R6: divide by zero, largest vector offset
    vec_in = 8'hFF; ssp_in = 32'h0000_7000;
    push_frame(10); pulse(11'h400, 1'b1); wait_all();

    chk(wq_a.size() == 0, "R9", "writes left unseen", wq_a.size(), 0);
    chk(dq_s.size() == 0, "R10", "frames left unserved", dq_s.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule